// File: doc/BRIEF.md
# Combinational Arithmetic, Shift and Logic Unit

This block is a purely combinational datapath unit. It takes two operands and a 5-bit function word, and it returns one result word and four condition flags. Inside are three units working in parallel: an adder/subtractor, a bidirectional barrel shifter built from power-of-two stages, and a bitwise logic unit. A final selector decides which unit drives the result.

The function word is not an opcode list. It is a set of independent control fields. Counting from the most significant bit, the fields are: `sub` at bit 4, a 2-bit `sel` at bits 3:2, `shft` at bit 1 and `math` at bit 0. The shifter moves operand B by a distance taken from the low bits of operand A. The two compare operations produce a single-bit answer in bit 0, and that answer is built from the adder flags.

Top module: `alu_core`

## Requirements
- R1: When math=1 and shft=0 and sub=0, and also when math=1 and shft=1 and sub=0, the result is A+B modulo 2^32.
- R2: When math=1, shft=0 and sub=1, the result is A−B modulo 2^32.
- R3: When math=1, shft=1, sub=1 and sel[0]=0, the result is 1 if A is less than B as signed two's-complement numbers, else 0. Bits 31:1 are always 0.
- R4: When math=1, shft=1, sub=1 and sel[0]=1, the result is 1 if A is less than B as unsigned numbers, else 0. Bits 31:1 are always 0.
- R5: When math=0 and shft=1, the result is B shifted by A[4:0]. sel=00 gives a logical left shift, sel=01 and sel=10 give a logical right shift, and sel=11 gives an arithmetic right shift. Logical shifts fill with zeros, and the arithmetic shift fills with B[31]. This holds for distances 0 through 31.
- R6: Bits 31:5 of A have no effect on any shift result.
- R7: When math=0 and shft=0, the result is bitwise: sel=00 gives AND, 01 gives OR, 10 gives XOR and 11 gives NOR of A and B.
- R8: zero_o is 1 exactly when the selected result is all zeros, for every function word.
- R9: For every function word, the adder computes A+B when sub=0 and A−B when sub=1, and neg_o, carry_o and ovf_o describe that adder output. neg_o is the sum's top bit. carry_o is the carry out of the top bit; for a subtraction it is 1 when no borrow occurs. ovf_o is signed overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A; its low 5 bits also give the shift distance |
| b_i | input | 32 | Operand B; this is the value that is shifted |
| fn_i | input | 5 | Function word {sub, sel[1:0], shft, math} |
| res_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the adder output |
| carry_o | output | 1 | Carry out of the adder |
| ovf_o | output | 1 | Signed overflow of the adder |

## Verification
The bench builds the block at its default width of 32, which gives a 5-bit shift distance and five shifter stages. At that width all 32 function words can be swept exhaustively. Each word is crossed with the corner operands 0, 1, all-ones, the most negative value and the most positive value. These operands reach a carry chain rippling across the full width, overflow in both directions, shifts by 0 and by 31, and sign filling. Random operands drawn from a fixed seed then cover the space between those corners, and directed vectors with the upper bits of A set show that those bits do not reach the shifter.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'b00,
    LOGIC_OR  = 2'b01,
    LOGIC_XOR = 2'b10,
    LOGIC_NOR = 2'b11
  } logic_op_e;

  typedef enum logic [1:0] {
    SHIFT_LL   = 2'b00,
    SHIFT_RL   = 2'b01,
    SHIFT_RL_B = 2'b10,
    SHIFT_RA   = 2'b11
  } shift_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // Subtraction adds the inverted operand plus one as carry in
  assign b_eff  = b_i ^ {WIDTH{sub_i}};
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (full[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  parameter int SHW   = 5
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   dist_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);

  logic fill;
  assign fill = arith_i & data_i[WIDTH-1];

  // Largest distance first; each stage is enabled by one bit of the distance
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << (SHW - 1 - k);
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] lft;
    logic [WIDTH-1:0] rgt;
    logic [WIDTH-1:0] q;

    if (k == 0) begin : g_first
      assign src = data_i;
    end else begin : g_next
      assign src = g_stage[k-1].q;
    end

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      if (j >= DIST) begin : g_lsrc
        assign lft[j] = src[j-DIST];
      end else begin : g_lzero
        assign lft[j] = 1'b0;
      end
      if (j + DIST < WIDTH) begin : g_rsrc
        assign rgt[j] = src[j+DIST];
      end else begin : g_rfill
        assign rgt[j] = fill;
      end
    end

    assign q = dist_i[SHW-1-k] ? (left_i ? lft : rgt) : src;
  end

  assign data_o = g_stage[SHW-1].q;

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);
  import alu_pkg::*;

  // Independent slice per bit position, no carry between slices
  for (genvar j = 0; j < WIDTH; j++) begin : g_slice
    always_comb begin
      unique case (logic_op_e'(sel_i))
        LOGIC_AND: y_o[j] = a_i[j] & b_i[j];
        LOGIC_OR:  y_o[j] = a_i[j] | b_i[j];
        LOGIC_XOR: y_o[j] = a_i[j] ^ b_i[j];
        LOGIC_NOR: y_o[j] = ~(a_i[j] | b_i[j]);
        default:   y_o[j] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [4:0]       fn_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);
  import alu_pkg::*;

  localparam int SHW = $clog2(WIDTH);

  alu_fn_t          fn;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] bitwise;
  logic [WIDTH-1:0] math_res;
  logic             cout;
  logic             ovf;
  logic             cmp_bit;
  logic             sh_left;
  logic             sh_arith;

  assign fn = alu_fn_t'(fn_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (fn.sub),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  assign sh_left  = (shift_op_e'(fn.sel) == SHIFT_LL);
  assign sh_arith = (shift_op_e'(fn.sel) == SHIFT_RA);

  alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shifter (
    .data_i  (b_i),
    .dist_i  (a_i[SHW-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .data_o  (shifted)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (fn.sel),
    .y_o   (bitwise)
  );

  // Compare: signed uses sign xor overflow, unsigned uses missing carry
  assign cmp_bit = fn.sel[0] ? ~cout : (sum[WIDTH-1] ^ ovf);

  always_comb begin
    if (fn.shft && fn.sub) begin
      math_res = {{(WIDTH-1){1'b0}}, cmp_bit};
    end else begin
      math_res = sum;
    end
  end

  always_comb begin
    if (fn.math) begin
      res_o = math_res;
    end else if (fn.shft) begin
      res_o = shifted;
    end else begin
      res_o = bitwise;
    end
  end

  assign zero_o  = ~|res_o;
  assign neg_o   = sum[WIDTH-1];
  assign carry_o = cout;
  assign ovf_o   = ovf;

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [4:0]       fn_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o
);

  logic is_add;
  logic is_sub;
  logic is_cmp;

  assign is_add = fn_i[0] && !fn_i[4];
  assign is_sub = fn_i[0] && !fn_i[1] && fn_i[4];
  assign is_cmp = fn_i[0] && fn_i[1] && fn_i[4];

  always_comb begin
    assert_zero_flag_R8: assert (zero_o == (res_o == '0))
      else $error("zero flag disagrees with result");
    if (is_add) begin
      assert_add_sum_R1: assert ({carry_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("add result or carry wrong");
    end
    if (is_sub) begin
      assert_sub_diff_R2: assert (res_o == (a_i - b_i))
        else $error("subtract result wrong");
    end
    if (is_cmp) begin
      assert_cmp_upper_R3: assert (res_o[WIDTH-1:1] == '0)
        else $error("compare upper bits not zero");
    end
    if (is_cmp && fn_i[2]) begin
      assert_ltu_bit_R4: assert (res_o[0] == (a_i < b_i))
        else $error("unsigned compare wrong");
    end
    if (fn_i[0] && !fn_i[4]) begin
      assert_add_neg_R9: assert (neg_o == res_o[WIDTH-1])
        else $error("negative flag disagrees with sum");
    end
    if (fn_i[0] && !fn_i[1] && (a_i[WIDTH-1] == b_i[WIDTH-1]) && !fn_i[4]) begin
      assert_add_ovf_R9: assert (ovf_o == (res_o[WIDTH-1] != a_i[WIDTH-1]))
        else $error("overflow flag wrong on add");
    end
  end

endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .fn_i    (fn_i),
  .res_o   (res_o),
  .zero_o  (zero_o),
  .neg_o   (neg_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [4:0]   fn;
  logic [W-1:0] res;
  logic         zero;
  logic         neg;
  logic         carry;
  logic         ovf;

  int checks;
  int failures;
  int cycles;
  bit done;

  alu_core #(.WIDTH(W)) uut (
    .a_i     (a),
    .b_i     (b),
    .fn_i    (fn),
    .res_o   (res),
    .zero_o  (zero),
    .neg_o   (neg),
    .carry_o (carry),
    .ovf_o   (ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference: {zero, neg, carry, ovf, result}
  function automatic logic [W+3:0] ref_model(input logic [W-1:0] ra, input logic [W-1:0] rb,
                                            input logic [4:0] rf);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         n;
    logic         c;
    logic         v;
    logic [4:0]   amt;
    amt = ra[4:0];
    if (rf[4]) s = {1'b0, ra} - {1'b0, rb};
    else       s = {1'b0, ra} + {1'b0, rb};
    n = s[W-1];
    c = rf[4] ? (ra >= rb) : s[W];
    if (rf[4]) v = (ra[W-1] != rb[W-1]) && (s[W-1] != ra[W-1]);
    else       v = (ra[W-1] == rb[W-1]) && (s[W-1] != ra[W-1]);
    if (rf[0]) begin
      if (rf[1] && rf[4]) begin
        if (rf[2]) r = {{(W-1){1'b0}}, (ra < rb)};
        else       r = {{(W-1){1'b0}}, ($signed(ra) < $signed(rb))};
      end else begin
        r = s[W-1:0];
      end
    end else if (rf[1]) begin
      case (rf[3:2])
        2'b00:   r = rb << amt;
        2'b11:   r = $unsigned($signed(rb) >>> amt);
        default: r = rb >> amt;
      endcase
    end else begin
      case (rf[3:2])
        2'b00:   r = ra & rb;
        2'b01:   r = ra | rb;
        2'b10:   r = ra ^ rb;
        default: r = ~(ra | rb);
      endcase
    end
    return {(r == '0), n, c, v, r};
  endfunction

  function automatic string req_of(input logic [4:0] rf);
    if (rf[0]) begin
      if (rf[4] && rf[1]) return rf[2] ? "R4" : "R3";
      if (rf[4]) return "R2";
      return "R1";
    end
    if (rf[1]) return "R5";
    return "R7";
  endfunction

  task automatic check_vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                           input logic [4:0] vf, input string tag);
    logic [W+3:0] exp;
    @(posedge clk);
    a  = va;
    b  = vb;
    fn = vf;
    @(negedge clk);
    exp = ref_model(va, vb, vf);
    checks++;
    if (res !== exp[W-1:0]) begin
      failures++;
      $display("FAIL %s fn=%b a=%h b=%h result actual=%h expected=%h",
               tag, vf, va, vb, res, exp[W-1:0]);
    end
    checks++;
    if (zero !== exp[W+3]) begin
      failures++;
      $display("FAIL R8 fn=%b a=%h b=%h zero actual=%b expected=%b", vf, va, vb, zero, exp[W+3]);
    end
    checks++;
    if ({neg, carry, ovf} !== exp[W+2:W]) begin
      failures++;
      $display("FAIL R9 fn=%b a=%h b=%h ncv actual=%b expected=%b",
               vf, va, vb, {neg, carry, ovf}, exp[W+2:W]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corners [5];
    int unused_seed;
    checks   = 0;
    failures = 0;
    cycles   = 0;
    done     = 1'b0;
    unused_seed = $urandom(32'd1234);
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF;
    a = '0; b = '0; fn = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiet start: AND of zeros must read zero with Z set (R7, R8)
    check_vec('0, '0, 5'b00000, "R7");

    // Every function word against all corner pairs
    for (int f = 0; f < 32; f++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          check_vec(corners[i], corners[j], 5'(f), req_of(5'(f)));
        end
      end
    end

    // Shift boundary distances 0 and 31 for each flavour (R5)
    for (int s = 0; s < 4; s++) begin
      check_vec(32'd0,  32'h8000_0001, {1'b0, 2'(s), 2'b10}, "R5");
      check_vec(32'd31, 32'h8000_0001, {1'b0, 2'(s), 2'b10}, "R5");
      check_vec(32'd31, 32'h4000_0000, {1'b0, 2'(s), 2'b10}, "R5");
    end

    // Upper bits of A must not reach the shifter (R6)
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        logic [W-1:0] rb;
        logic [W-1:0] ra;
        rb = $urandom;
        ra = {$urandom} | 32'hFFFF_FFE0;
        check_vec(ra, rb, {1'b0, 2'(s), 2'b10}, "R6");
      end
    end

    // Random operands for every function word
    for (int f = 0; f < 32; f++) begin
      for (int k = 0; k < 40; k++) begin
        check_vec($urandom, $urandom, 5'(f), req_of(5'(f)));
      end
    end

    // Equal operands: subtract gives zero, compares give zero (R2, R3, R4, R8)
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] v;
      v = $urandom;
      check_vec(v, v, 5'b10001, "R2");
      check_vec(v, v, 5'b10011, "R3");
      check_vec(v, v, 5'b10111, "R4");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule